// File: doc/BRIEF.md
# SMI Group Interrupt Aggregator

This block gathers many interrupt sources into one system-management interrupt (SMI). There are two kinds of source. Fixed peripheral requests appear as live status bits. General-purpose inputs are first synchronised. They then latch a sticky status bit on an edge chosen per bit. Software clears a sticky bit by writing 1 to it. Each status bit has a matching enable bit. The internal SMI is asserted when any status bit and its enable are both set.

The internal SMI goes to three destinations, and each destination has its own enable bit:
- a dedicated output pin;
- a request strobe for a serial interrupt frame slot;
- a device-interrupt request into power-management-event logic.

The pin's polarity is programmable, and so is its drive mode (open-drain or push-pull). Software reaches all registers through a simple write port and a combinational read port. The byte map:
- 0: fixed status, read-only.
- 1: fixed enable.
- 2: GPIO status, write-1-to-clear.
- 3: GPIO enable.
- 4: routing. Bit 7 is the pin, bit 6 the serial slot, bit 5 the power event.
- 5: GPIO falling-edge select.
- 6: GPIO both-edge select.
- 7: pin control. Bit 7 selects push-pull, bit 0 selects active-high.

Top module: `smi_group_agg`

## Requirements
- R1: The internal SMI is the OR over all sources of (status AND enable), covering both the fixed sources (status at address 0, enable at address 1) and the GPIO sources (status at address 2, enable at address 3).
- R2: The pin is asserted only when the internal SMI is high and routing bit 7 (address 4) is set.
- R3: `sirq_req_o` equals the internal SMI gated by routing bit 6.
- R4: `pme_req_o` equals the internal SMI gated by routing bit 5.
- R5: After reset all registers read 0. The pin is then active-low and open-drain: when it is inactive, `smi_pin_oe`=0; when it is asserted, `smi_pin_oe`=1 with `smi_pin_o`=0. Open-drain mode never drives `smi_pin_o` high.
- R6: With pin-control bit 7 set (push-pull), `smi_pin_oe` is 1 at all times. Pin-control bit 0 set makes the asserted level 1; cleared, it makes the asserted level 0.
- R7: With falling-select and both-select clear, a GPIO status bit sets on a 0-to-1 input transition and not on 1-to-0.
- R8: With the falling-select bit (address 5) set, the status bit sets on 1-to-0 and not on 0-to-1.
- R9: With the both-select bit (address 6) set, either transition sets the status bit.
- R10: Writing 1 to a GPIO status bit clears it, writing 0 leaves it unchanged, and a status bit never falls without such a write.
- R11: A detected edge in the same cycle as a clearing write leaves the bit set.
- R12: A GPIO input change driven before clock edge k shows in status after edge k+2, and not after edge k+1.
- R13: Fixed status reads back the live fixed inputs, and writes to address 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | DW (8) | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | DW (8) | Combinational read data |
| fix_irq_i | input | N_FIX (8) | Fixed peripheral interrupt levels (synchronous) |
| gpio_i | input | N_GPIO (8) | Asynchronous general-purpose inputs |
| smi_pin_o | output | 1 | Pin data value |
| smi_pin_oe | output | 1 | Pin output enable |
| sirq_req_o | output | 1 | Serial interrupt slot request |
| pme_req_o | output | 1 | Power-management-event device-interrupt request |

## Verification
The assertions assume that the fixed interrupt inputs and the register port are synchronous to `clk`. Only the GPIO inputs may change at any time. The write-1-to-clear property also assumes that a status bit changes only through a write or a detected edge. The stimulus drives every input at the falling clock edge and holds each GPIO level for several cycles, so the synchroniser sees a clean transition. Same-cycle set and clear is reached on purpose by timing a write to land on the cycle in which the edge is detected.

// File: rtl/smi_agg_pkg.sv
package smi_agg_pkg;
  localparam int unsigned REG_AW = 3;

  localparam logic [REG_AW-1:0] ADR_FSTS   = 3'd0;
  localparam logic [REG_AW-1:0] ADR_FEN    = 3'd1;
  localparam logic [REG_AW-1:0] ADR_GSTS   = 3'd2;
  localparam logic [REG_AW-1:0] ADR_GEN    = 3'd3;
  localparam logic [REG_AW-1:0] ADR_ROUTE  = 3'd4;
  localparam logic [REG_AW-1:0] ADR_GFALL  = 3'd5;
  localparam logic [REG_AW-1:0] ADR_GBOTH  = 3'd6;
  localparam logic [REG_AW-1:0] ADR_PINCTL = 3'd7;

  // bit positions in the register byte
  localparam int unsigned BIT_RT_PIN  = 7;
  localparam int unsigned BIT_RT_SIRQ = 6;
  localparam int unsigned BIT_RT_PME  = 5;
  localparam int unsigned BIT_PC_PP   = 7;
  localparam int unsigned BIT_PC_HIGH = 0;

  // stored routing fields
  typedef struct packed {
    logic pin;
    logic sirq;
    logic pme;
  } route_t;

  // stored pin control fields
  typedef struct packed {
    logic push_pull;
    logic act_high;
  } pinctl_t;

  function automatic logic edge_hit(input logic cur, input logic prev,
                                    input logic fall_sel, input logic both_sel);
    logic rise;
    logic fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    if (both_sel) return rise | fall;
    return fall_sel ? fall : rise;
  endfunction

  function automatic logic pin_level(input logic active, input logic act_high);
    return act_high ? active : ~active;
  endfunction
endpackage

// File: rtl/smi_gpio_edge.sv
module smi_gpio_edge
  import smi_agg_pkg::*;
#(
  parameter int unsigned N_GPIO = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_GPIO-1:0] gpio_i,
  input  logic [N_GPIO-1:0] fall_sel,
  input  logic [N_GPIO-1:0] both_sel,
  output logic [N_GPIO-1:0] hit_o
);
  for (genvar i = 0; i < N_GPIO; i++) begin : g_bit
    logic meta_q, sync_q, prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= gpio_i[i];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end
    assign hit_o[i] = edge_hit(sync_q, prev_q, fall_sel[i], both_sel[i]);
  end
endmodule

// File: rtl/smi_regs.sv
module smi_regs
  import smi_agg_pkg::*;
#(
  parameter int unsigned DW     = 8,
  parameter int unsigned N_FIX  = 8,
  parameter int unsigned N_GPIO = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [DW-1:0]     rd_data,
  input  logic [N_FIX-1:0]  fix_irq,
  input  logic [N_GPIO-1:0] gpio_hit,
  output logic [N_FIX-1:0]  fen_q,
  output logic [N_GPIO-1:0] gsts_q,
  output logic [N_GPIO-1:0] gen_q,
  output logic [N_GPIO-1:0] gfall_q,
  output logic [N_GPIO-1:0] gboth_q,
  output route_t            route_q,
  output pinctl_t           pinctl_q,
  output logic [N_GPIO-1:0] clr_mask
);
  logic wr_fen, wr_gsts, wr_gen, wr_route, wr_gfall, wr_gboth, wr_pinctl;

  assign wr_fen    = wr_en && (wr_addr == ADR_FEN);
  assign wr_gsts   = wr_en && (wr_addr == ADR_GSTS);
  assign wr_gen    = wr_en && (wr_addr == ADR_GEN);
  assign wr_route  = wr_en && (wr_addr == ADR_ROUTE);
  assign wr_gfall  = wr_en && (wr_addr == ADR_GFALL);
  assign wr_gboth  = wr_en && (wr_addr == ADR_GBOTH);
  assign wr_pinctl = wr_en && (wr_addr == ADR_PINCTL);

  assign clr_mask = wr_gsts ? wr_data[N_GPIO-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fen_q    <= '0;
      gsts_q   <= '0;
      gen_q    <= '0;
      gfall_q  <= '0;
      gboth_q  <= '0;
      route_q  <= '0;
      pinctl_q <= '0;
    end else begin
      // a fresh edge takes precedence over a clear in the same cycle
      gsts_q <= (gsts_q & ~clr_mask) | gpio_hit;
      if (wr_fen)   fen_q   <= wr_data[N_FIX-1:0];
      if (wr_gen)   gen_q   <= wr_data[N_GPIO-1:0];
      if (wr_gfall) gfall_q <= wr_data[N_GPIO-1:0];
      if (wr_gboth) gboth_q <= wr_data[N_GPIO-1:0];
      if (wr_route) begin
        route_q.pin  <= wr_data[BIT_RT_PIN];
        route_q.sirq <= wr_data[BIT_RT_SIRQ];
        route_q.pme  <= wr_data[BIT_RT_PME];
      end
      if (wr_pinctl) begin
        pinctl_q.push_pull <= wr_data[BIT_PC_PP];
        pinctl_q.act_high  <= wr_data[BIT_PC_HIGH];
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADR_FSTS:  rd_data = DW'(fix_irq);
      ADR_FEN:   rd_data = DW'(fen_q);
      ADR_GSTS:  rd_data = DW'(gsts_q);
      ADR_GEN:   rd_data = DW'(gen_q);
      ADR_GFALL: rd_data = DW'(gfall_q);
      ADR_GBOTH: rd_data = DW'(gboth_q);
      ADR_ROUTE: begin
        rd_data[BIT_RT_PIN]  = route_q.pin;
        rd_data[BIT_RT_SIRQ] = route_q.sirq;
        rd_data[BIT_RT_PME]  = route_q.pme;
      end
      default: begin
        rd_data[BIT_PC_PP]   = pinctl_q.push_pull;
        rd_data[BIT_PC_HIGH] = pinctl_q.act_high;
      end
    endcase
  end
endmodule

// File: rtl/smi_out_steer.sv
module smi_out_steer
  import smi_agg_pkg::*;
(
  input  logic    smi_int,
  input  route_t  route,
  input  pinctl_t pinctl,
  output logic    pin_active,
  output logic    pin_o,
  output logic    pin_oe,
  output logic    sirq_req,
  output logic    pme_req
);
  logic level;

  assign pin_active = smi_int & route.pin;
  assign level      = pin_level(pin_active, pinctl.act_high);
  assign sirq_req   = smi_int & route.sirq;
  assign pme_req    = smi_int & route.pme;

  always_comb begin
    if (pinctl.push_pull) begin
      pin_o  = level;
      pin_oe = 1'b1;
    end else begin
      pin_o  = 1'b0;
      pin_oe = ~level;
    end
  end
endmodule

// File: rtl/smi_group_agg.sv
module smi_group_agg
  import smi_agg_pkg::*;
#(
  parameter int unsigned DW     = 8,
  parameter int unsigned N_FIX  = 8,
  parameter int unsigned N_GPIO = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [2:0]        rd_addr,
  output logic [DW-1:0]     rd_data,
  input  logic [N_FIX-1:0]  fix_irq_i,
  input  logic [N_GPIO-1:0] gpio_i,
  output logic              smi_pin_o,
  output logic              smi_pin_oe,
  output logic              sirq_req_o,
  output logic              pme_req_o
);
  logic [N_FIX-1:0]  fen;
  logic [N_GPIO-1:0] gsts, gen, gfall, gboth, gpio_hit, clr_mask;
  route_t            route;
  pinctl_t           pinctl;
  logic              smi_int;
  logic              pin_active;

  smi_gpio_edge #(.N_GPIO(N_GPIO)) u_edge (
    .clk(clk), .rst_n(rst_n), .gpio_i(gpio_i),
    .fall_sel(gfall), .both_sel(gboth), .hit_o(gpio_hit)
  );

  smi_regs #(.DW(DW), .N_FIX(N_FIX), .N_GPIO(N_GPIO)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .fix_irq(fix_irq_i), .gpio_hit(gpio_hit), .fen_q(fen),
    .gsts_q(gsts), .gen_q(gen), .gfall_q(gfall), .gboth_q(gboth),
    .route_q(route), .pinctl_q(pinctl), .clr_mask(clr_mask)
  );

  assign smi_int = (|(fix_irq_i & fen)) | (|(gsts & gen));

  smi_out_steer u_steer (
    .smi_int(smi_int), .route(route), .pinctl(pinctl),
    .pin_active(pin_active), .pin_o(smi_pin_o), .pin_oe(smi_pin_oe),
    .sirq_req(sirq_req_o), .pme_req(pme_req_o)
  );
endmodule

// File: rtl/smi_agg_chk.sv
module smi_agg_chk
  import smi_agg_pkg::*;
#(
  parameter int unsigned N_GPIO = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smi_int,
  input logic              pin_active,
  input route_t            route,
  input pinctl_t           pinctl,
  input logic              smi_pin_o,
  input logic              smi_pin_oe,
  input logic              sirq_req_o,
  input logic              pme_req_o,
  input logic [N_GPIO-1:0] gsts,
  input logic [N_GPIO-1:0] gpio_hit,
  input logic [N_GPIO-1:0] clr_mask
);
  AST_PIN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    pin_active |-> (smi_int && route.pin)); // R2
  AST_SIRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    sirq_req_o |-> (smi_int && route.sirq)); // R3
  AST_PME_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    pme_req_o |-> (smi_int && route.pme)); // R4
  AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !pinctl.push_pull |-> !smi_pin_o); // R5
  AST_PP_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    pinctl.push_pull |-> smi_pin_oe); // R6
  AST_CLEAR_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(gsts) & ~gsts & ~$past(clr_mask)) == '0)); // R10
  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((gsts & $past(gpio_hit)) == $past(gpio_hit))); // R11
endmodule

bind smi_group_agg smi_agg_chk #(.N_GPIO(N_GPIO)) u_chk (
  .clk(clk), .rst_n(rst_n), .smi_int(smi_int), .pin_active(pin_active),
  .route(route), .pinctl(pinctl), .smi_pin_o(smi_pin_o),
  .smi_pin_oe(smi_pin_oe), .sirq_req_o(sirq_req_o), .pme_req_o(pme_req_o),
  .gsts(gsts), .gpio_hit(gpio_hit), .clr_mask(clr_mask)
);

// File: tb/tb_smi_group_agg.sv
module tb_smi_group_agg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [7:0] fix_irq_i = '0;
  logic [7:0] gpio_i = '0;
  logic smi_pin_o, smi_pin_oe, sirq_req_o, pme_req_o;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  smi_group_agg dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .fix_irq_i(fix_irq_i), .gpio_i(gpio_i), .smi_pin_o(smi_pin_o),
    .smi_pin_oe(smi_pin_oe), .sirq_req_o(sirq_req_o), .pme_req_o(pme_req_o)
  );

  // fix, fen, route, pinctl, expected {pin_o, pin_oe, sirq, pme}
  localparam int NV = 12;
  localparam logic [35:0] VEC [NV] = '{
    {8'h01, 8'h01, 8'hE0, 8'h00, 4'b0111},  // R1 R5 asserted low
    {8'h01, 8'h02, 8'hE0, 8'h00, 4'b0000},  // R1 enable mismatch
    {8'h80, 8'h80, 8'h80, 8'h00, 4'b0100},  // R2 pin only
    {8'h80, 8'h80, 8'h40, 8'h00, 4'b0010},  // R3 sirq only
    {8'h80, 8'h80, 8'h20, 8'h00, 4'b0001},  // R4 pme only
    {8'hFF, 8'h00, 8'hE0, 8'h00, 4'b0000},  // R1 nothing enabled
    {8'h10, 8'h10, 8'h80, 8'h81, 4'b1100},  // R6 pp high active
    {8'h00, 8'h10, 8'h80, 8'h81, 4'b0100},  // R6 pp high idle
    {8'h10, 8'h10, 8'h80, 8'h80, 4'b0100},  // R6 pp low active
    {8'h00, 8'h10, 8'h80, 8'h80, 4'b1100},  // R6 pp low idle
    {8'h10, 8'h10, 8'h80, 8'h01, 4'b0000},  // R5 od high active releases
    {8'h00, 8'h10, 8'h80, 8'h01, 4'b0100}   // R5 od high idle pulls low
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rdchk(input string tag, input logic [2:0] a, input logic [7:0] exp);
    rd_addr = a;
    #1;
    chk(tag, {24'h0, rd_data}, {24'h0, exp});
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog got=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // reset state R5
    for (int a = 1; a < 8; a++) rdchk("R5 reset reg", 3'(a), 8'h00);
    chk("R5 reset pins", {28'h0, smi_pin_o, smi_pin_oe, sirq_req_o, pme_req_o}, 32'h0);

    // vector table: R1..R6
    for (int v = 0; v < NV; v++) begin
      wr(3'd1, VEC[v][35:28]);
      fix_irq_i = VEC[v][35:28];
      wr(3'd1, VEC[v][27:20]);
      wr(3'd4, VEC[v][19:12]);
      wr(3'd7, VEC[v][11:4]);
      #1;
      chk($sformatf("R1-vector %0d", v),
          {28'h0, smi_pin_o, smi_pin_oe, sirq_req_o, pme_req_o}, {28'h0, VEC[v][3:0]});
    end
    wr(3'd1, 8'h00);
    wr(3'd7, 8'h00);
    wr(3'd4, 8'h20);
    fix_irq_i = 8'h00;

    // R13 fixed status read-only
    fix_irq_i = 8'h5A;
    rdchk("R13 live", 3'd0, 8'h5A);
    wr(3'd0, 8'hFF);
    rdchk("R13 write ignored", 3'd0, 8'h5A);
    fix_irq_i = 8'h00;

    // R12 synchroniser latency, R7 rising sets
    rd_addr = 3'd2;
    gpio_i[0] = 1'b1;
    cyc(1); rdchk("R12 after edge 1", 3'd2, 8'h00);
    cyc(1); rdchk("R12 after edge 2", 3'd2, 8'h00);
    cyc(1); rdchk("R12 R7 after edge 3", 3'd2, 8'h01);
    // R1 GPIO path
    #1; chk("R1 gpio disabled", {31'h0, pme_req_o}, 32'h0);
    wr(3'd3, 8'h01);
    #1; chk("R1 gpio enabled", {31'h0, pme_req_o}, 32'h1);
    // R10 write 0 keeps, write 1 clears
    wr(3'd2, 8'h00);
    rdchk("R10 write zero", 3'd2, 8'h01);
    wr(3'd2, 8'h01);
    rdchk("R10 write one", 3'd2, 8'h00);
    // R7 falling does not set
    gpio_i[0] = 1'b0;
    cyc(5); rdchk("R7 fall ignored", 3'd2, 8'h00);

    // R8 inverted polarity
    wr(3'd5, 8'h02);
    gpio_i[1] = 1'b1;
    cyc(5); rdchk("R8 rise ignored", 3'd2, 8'h00);
    gpio_i[1] = 1'b0;
    cyc(5); rdchk("R8 fall sets", 3'd2, 8'h02);
    wr(3'd2, 8'h02);

    // R9 both edges
    wr(3'd6, 8'h0C);
    gpio_i[2] = 1'b1;
    cyc(5); rdchk("R9 rise sets", 3'd2, 8'h04);
    wr(3'd2, 8'h04);
    gpio_i[2] = 1'b0;
    cyc(5); rdchk("R9 fall sets", 3'd2, 8'h04);
    wr(3'd2, 8'h04);
    rdchk("R9 cleared", 3'd2, 8'h00);

    // R11 edge and clear in same cycle
    gpio_i[3] = 1'b1;
    cyc(5); rdchk("R11 preset", 3'd2, 8'h08);
    gpio_i[3] = 1'b0;
    cyc(2);               // edge detected between 2nd and 3rd clock edge
    wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'h08;
    cyc(1);
    wr_en = 1'b0;
    rdchk("R11 set wins", 3'd2, 8'h08);
    wr(3'd2, 8'h08);
    rdchk("R11 later clear", 3'd2, 8'h00);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule